// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block lets a host drive a small three-wire serial configuration EEPROM through two 16-bit registers. The host writes a command word naming an operation and a word address. For a write, it first loads the word to be stored into a separate data register. For a read, it collects the returned word from that data register once the operation has finished. While a frame is on the wire, the top bit of the command register reads as 1.

Each serial frame opens with a start bit of 1. A 2-bit opcode follows, then the word address, most significant bit first. Read and write frames then carry 16 data bits, also most significant bit first. The serial clock runs at the system clock divided by `CLK_DIV`. Chip select goes high for the whole frame and is then held low for one full serial-clock period before busy clears.

The block keeps its own erase/write-enable latch. Write and erase requests are dropped without touching the serial lines until an enable command has been accepted.

Top module: `eectl`

## Requirements
- R1: A command word with bits [7:6]=2'b10 and the word address in bits [5:0] (0x0080|addr) sends start bit 1, opcode 10 and the address. It then samples 16 data bits, MSB first, on the serial data-out line and loads them into the data register. The EEPROM shifts each data bit out after a falling serial clock, and there is no leading dummy bit.
- R2: A command word with bits [7:6]=2'b01 (0x0040|addr) is accepted only once enable has been latched. It sends start bit 1, opcode 01, the address and then the data register MSB first, and the addressed word afterwards holds that value.
- R3: A command word with bits [7:6]=2'b11 (0x00C0|addr) is accepted only once enable has been latched. It sends start bit 1, opcode 11 and the address with no data bits, and the addressed word afterwards reads 0xFFFF.
- R4: The command word 0x0030 (bits [7:6]=00 and bits [5:4]=11) sends the header frame 1,00,110000 and sets the enable latch, which only reset clears. Any other command word with bits [7:6]=00 is dropped.
- R5: A write or erase command accepted before the enable latch is set causes no frame: chip select stays low and busy stays 0.
- R6: Busy (command register bit 15) is 1 starting the cycle after a command that launches a frame, for (frame bits + 1) x CLK_DIV cycles. Chip select is high for the first frame bits x CLK_DIV of those cycles. A frame is 9 bits for enable and erase and 25 bits for read and write.
- R7: A command word written while busy is ignored. Neither the stored command bits nor the operation change.
- R8: Command bit 14 is stored and reads back in bit 14 of the command register. It has no effect on the operation decoded from bits [7:0].
- R9: The data register is separate from the command register and always reads back its contents. A host data write is taken only while not busy; a data write during busy is ignored.
- R10: The serial clock is low for the first CLK_DIV/2 cycles of each bit period and high for the rest. It is low whenever chip select is low, and chip select stays low for at least CLK_DIV cycles between frames.
- R11: The address field spans 6 bits, so all 64 words (0x00 to 0x3F) are reachable.
- R12: After reset, the command register reads 0, the data register reads 0, and chip select, serial clock and serial data-in are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 16 | Command word written by the host |
| cmd_rdata | output | 16 | Command register: busy in bit 15, test bit in bit 14, last command in bits [7:0] |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Word to be written to the EEPROM |
| data_rdata | output | 16 | Data register contents |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
A sequencer stuck in the wrong state, or a bit counter that is off by one, shows at the ports within one clock. The busy bit and chip select are compared against a per-cycle reference on every edge, so a frame that is one bit short or long is caught on the first cycle where they differ. A corrupted shift register or a bit-order error only shows later, as a wrong word read back through the data register once the frame has finished. A wrong enable latch shows either as chip select rising for a refused write, or as a stored word that does not change.

// File: rtl/eectl_pkg.sv
// Shared types for the serial EEPROM command controller.
// Assumes a 16-bit EEPROM word and a 2-bit opcode field.
package eectl_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_MISC  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } ee_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_SHIFT = 2'b01,
        SQ_GAP   = 2'b10
    } sq_state_e;
endpackage

// File: rtl/eectl_sk_gen.sv
// Bit-period timer: counts system clocks within one serial-clock period.
// Assumes CLK_DIV is even and at least 2; the count restarts while run is low.
module eectl_sk_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_hi,
    output logic period_end
);
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HALF  = CLK_DIV / 2;

    logic [CNT_W-1:0] cnt_q;

    // Advance the period counter while a frame or gap is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(CLK_DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase_hi   = (cnt_q >= CNT_W'(HALF));
    assign period_end = run && (cnt_q == CNT_W'(CLK_DIV - 1));
endmodule

// File: rtl/eectl_shift.sv
// Frame sequencer: shifts start bit, opcode, address and optional data
// out, samples returned data bits, then holds chip select low for one
// bit period. Assumes start is only raised while busy is low.
module eectl_shift
    import eectl_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  ee_op_e            start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              ee_do,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di
);
    localparam int HDR_W   = 3 + ADDR_W;
    localparam int FRAME_W = HDR_W + WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    sq_state_e          state_q;
    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   left_q;
    logic [WORD_W-1:0]  rx_q;
    logic               done_q;
    logic               phase_hi;
    logic               period_end;

    eectl_sk_gen #(.CLK_DIV(CLK_DIV)) u_sk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q != SQ_IDLE),
        .phase_hi  (phase_hi),
        .period_end(period_end)
    );

    // Step through idle, shifting and the closing chip-select gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            frame_q <= '0;
            left_q  <= '0;
            rx_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        state_q <= SQ_SHIFT;
                        frame_q <= {1'b1, start_op, start_addr,
                                    (start_op == OP_WRITE) ? tx_word : {WORD_W{1'b0}}};
                        left_q  <= (start_op == OP_READ || start_op == OP_WRITE)
                                   ? CNT_W'(FRAME_W) : CNT_W'(HDR_W);
                    end
                end
                SQ_SHIFT: begin
                    if (period_end) begin
                        frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                        rx_q    <= {rx_q[WORD_W-2:0], ee_do};
                        left_q  <= left_q - 1'b1;
                        if (left_q == CNT_W'(1)) begin
                            state_q <= SQ_GAP;
                            done_q  <= 1'b1;
                        end
                    end
                end
                SQ_GAP: begin
                    if (period_end) begin
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != SQ_IDLE);
    assign done    = done_q;
    assign rx_word = rx_q;
    assign ee_cs   = (state_q == SQ_SHIFT);
    assign ee_sk   = ee_cs && phase_hi;
    assign ee_di   = ee_cs && frame_q[FRAME_W-1];
endmodule

// File: rtl/eectl.sv
// Host-side serial EEPROM command controller: command and data registers,
// enable latch and command decode around the frame sequencer.
// Assumes ADDR_W <= 12 so the command fields fit in 14 bits.
module eectl
    import eectl_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [15:0] cmd_wdata,
    output logic [15:0] cmd_rdata,
    input  logic        data_wr,
    input  logic [15:0] data_wdata,
    output logic [15:0] data_rdata,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do
);
    localparam int LO_W  = 2 + ADDR_W;
    localparam int PAD_W = 14 - LO_W;
    localparam int TEST_BIT = 14;

    logic [LO_W-1:0]   cmd_lo_q;
    logic              test_q;
    logic              wr_en_q;
    logic              rd_pend_q;
    logic [WORD_W-1:0] data_q;

    logic              busy;
    logic              done;
    logic [WORD_W-1:0] rx_word;
    logic              accept;
    logic              launch;
    logic              is_enable;
    ee_op_e            op;
    logic [ADDR_W-1:0] addr;

    // Decode the incoming command word and decide whether it starts a frame.
    always_comb begin
        op        = ee_op_e'(cmd_wdata[ADDR_W+1:ADDR_W]);
        addr      = cmd_wdata[ADDR_W-1:0];
        accept    = cmd_wr && !busy;
        is_enable = (op == OP_MISC) && (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
        launch    = accept && ((op == OP_READ) || is_enable ||
                    (((op == OP_WRITE) || (op == OP_ERASE)) && wr_en_q));
    end

    // Hold the command bits, test bit, enable latch and pending-read flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_lo_q  <= '0;
            test_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            if (accept) begin
                cmd_lo_q <= cmd_wdata[LO_W-1:0];
                test_q   <= cmd_wdata[TEST_BIT];
                if (is_enable) begin
                    wr_en_q <= 1'b1;
                end
            end
            if (launch) begin
                rd_pend_q <= (op == OP_READ);
            end else if (done) begin
                rd_pend_q <= 1'b0;
            end
        end
    end

    // Data register: host writes when idle, read result at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done && rd_pend_q) begin
            data_q <= rx_word;
        end else if (data_wr && !busy) begin
            data_q <= data_wdata;
        end
    end

    eectl_shift #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (launch),
        .start_op  (op),
        .start_addr(addr),
        .tx_word   (data_q),
        .ee_do     (ee_do),
        .busy      (busy),
        .done      (done),
        .rx_word   (rx_word),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di)
    );

    assign cmd_rdata  = {busy, test_q, {PAD_W{1'b0}}, cmd_lo_q};
    assign data_rdata = data_q;
endmodule

// File: rtl/eectl_chk.sv
// Port-level protocol checker for eectl, bound to every instance.
// Keeps a shadow of accepted enable commands and a count of idle cycles.
module eectl_chk #(
    parameter int ADDR_W  = 6,
    parameter int CLK_DIV = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [15:0] cmd_wdata,
    input logic [15:0] cmd_rdata,
    input logic        data_wr,
    input logic [15:0] data_wdata,
    input logic [15:0] data_rdata,
    input logic        ee_cs,
    input logic        ee_sk,
    input logic        ee_di,
    input logic        ee_do
);
    localparam int GW = $clog2(CLK_DIV + 2) + 1;

    logic          en_seen_q;
    logic [GW-1:0] gap_q;
    logic [1:0]    op_in;
    logic          wr_req;

    assign op_in  = cmd_wdata[ADDR_W+1:ADDR_W];
    assign wr_req = cmd_wr && !cmd_rdata[15] && (op_in[0] == 1'b1);

    // Track whether an enable command has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_seen_q <= 1'b0;
        end else if (cmd_wr && !cmd_rdata[15] && op_in == 2'b00 &&
                     cmd_wdata[ADDR_W-1:ADDR_W-2] == 2'b11) begin
            en_seen_q <= 1'b1;
        end
    end

    // Count consecutive low chip-select cycles, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GW'(CLK_DIV);
        end else if (ee_cs) begin
            gap_q <= '0;
        end else if (gap_q < GW'(CLK_DIV + 1)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_no_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !en_seen_q) |=> !ee_cs);

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (gap_q >= GW'(CLK_DIV)));

    p_sk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    p_cs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs |-> cmd_rdata[15]);

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rdata[15] && cmd_wr) |=> $stable(cmd_rdata[14:0]));
endmodule

bind eectl eectl_chk #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_chk (.*);

// File: tb/eectl_bench.sv
// Bench for eectl: behavioural EEPROM, per-cycle busy/select/clock reference.
module eectl_bench;
    localparam int DIV  = 4;
    localparam int AW   = 6;
    localparam int HDR  = 3 + AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] cmd_rdata;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [15:0] data_rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    eectl #(.ADDR_W(AW), .CLK_DIV(DIV)) u_eectl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rdata(data_rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural EEPROM ----------------
    logic [15:0] mem [64];
    logic [15:0] exp_mem [64];
    logic [HDR-1:0] hdr;
    logic [15:0] wbuf;
    int  nbit;
    bit  dev_en;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 16'hA5A5 ^ (16'(i) * 16'h0101);
            exp_mem[i] = 16'hA5A5 ^ (16'(i) * 16'h0101);
        end
        dev_en = 1'b0;
        nbit = 0;
    end

    always @(posedge ee_cs) begin
        nbit = 0;
        ee_do = 1'b0;
    end

    always @(posedge ee_sk) begin
        if (ee_cs) begin
            nbit++;
            if (nbit <= HDR) hdr = {hdr[HDR-2:0], ee_di};
            else wbuf = {wbuf[14:0], ee_di};
        end
    end

    always @(negedge ee_sk) begin
        if (ee_cs && nbit >= HDR && hdr[HDR-2:HDR-3] == 2'b10) begin
            if (nbit - HDR <= 15) ee_do = mem[hdr[AW-1:0]][15 - (nbit - HDR)];
            else ee_do = 1'b0;
        end
    end

    always @(negedge ee_cs) begin
        if (hdr[HDR-1] == 1'b1) begin
            case (hdr[HDR-2:HDR-3])
                2'b01: if (dev_en && nbit == HDR + 16) mem[hdr[AW-1:0]] = wbuf;
                2'b11: if (dev_en && nbit == HDR) mem[hdr[AW-1:0]] = 16'hFFFF;
                2'b00: if (hdr[AW-1:AW-2] == 2'b11) dev_en = 1'b1;
                default: ;
            endcase
        end
        ee_do = 1'b0;
    end

    // ---------------- cycle reference for busy / cs / sk ----------------
    int rem = 0;
    int tot = 0;
    bit ref_en = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0;
            ref_en = 0;
        end else if (rem > 0) begin
            rem--;
        end else if (cmd_wr) begin
            logic [1:0] op;
            logic [5:0] a;
            op = cmd_wdata[7:6];
            a  = cmd_wdata[5:0];
            tot = 0;
            if (op == 2'b10) tot = (HDR + 16 + 1) * DIV;
            else if (op == 2'b00 && a[5:4] == 2'b11) begin
                tot = (HDR + 1) * DIV;
                ref_en = 1;
            end
            else if (op == 2'b01 && ref_en) tot = (HDR + 16 + 1) * DIV;
            else if (op == 2'b11 && ref_en) tot = (HDR + 1) * DIV;
            rem = tot;
        end
    end

    // R6 / R10: compare busy, select and serial clock every cycle
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 busy", {15'b0, cmd_rdata[15]}, {15'b0, rem > 0});
            chk("R6 cs", {15'b0, ee_cs}, {15'b0, rem > DIV});
            chk("R10 sk", {15'b0, ee_sk},
                {15'b0, (rem > DIV) && (((tot - rem) % DIV) >= DIV / 2)});
        end
    end

    // ---------------- host tasks ----------------
    task automatic issue_cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic put_data(input logic [15:0] w);
        @(negedge clk);
        data_wr = 1'b1;
        data_wdata = w;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (rem > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_word(input logic [5:0] a, input string tag);
        issue_cmd(16'h0080 | 16'(a));
        wait_idle();
        chk(tag, data_rdata, exp_mem[a]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 cmd reset", cmd_rdata, 16'h0000);
        chk("R12 data reset", data_rdata, 16'h0000);
        chk("R12 lines reset", {13'b0, ee_cs, ee_sk, ee_di}, 16'h0000);
        rst_n = 1'b1;

        // R9: data register written while idle reads back, command untouched
        put_data(16'h5A3C);
        chk("R9 data idle write", data_rdata, 16'h5A3C);
        chk("R9 cmd unaffected", cmd_rdata, 16'h0000);

        // R5: write and erase refused before enable
        issue_cmd(16'h0045);
        @(negedge clk);
        chk("R5 write dropped busy", cmd_rdata, 16'h0045);
        issue_cmd(16'h00C6);
        @(negedge clk);
        chk("R5 erase dropped busy", cmd_rdata, 16'h00C6);
        read_word(6'd5, "R5 word5 intact");
        read_word(6'd6, "R5 word6 intact");

        // R4: other misc commands are dropped
        issue_cmd(16'h0010);
        @(negedge clk);
        chk("R4 misc dropped", {15'b0, cmd_rdata[15]}, 16'h0000);

        // R1 / R11: reads across the address range
        read_word(6'd0, "R1 read addr0");
        read_word(6'h3F, "R11 read addr63");
        read_word(6'h2A, "R1 read addr42");

        // R7: command written while busy is ignored
        issue_cmd(16'h0081);
        issue_cmd(16'h00C7);
        chk("R7 cmd kept", cmd_rdata[14:0], 15'h0081);
        wait_idle();
        chk("R7 first read result", data_rdata, exp_mem[1]);
        chk("R7 no erase after", cmd_rdata, 16'h0081);

        // R4: enable
        issue_cmd(16'h0030);
        wait_idle();
        chk("R4 enable readback", cmd_rdata, 16'h0030);

        // R2 / R9: write, data write during busy ignored
        put_data(16'h1234);
        issue_cmd(16'h0045);
        put_data(16'hBEEF);
        wait_idle();
        exp_mem[5] = 16'h1234;
        chk("R9 busy data write ignored", data_rdata, 16'h1234);
        read_word(6'd5, "R2 write stored");

        put_data(16'h8001);
        issue_cmd(16'h007F);
        wait_idle();
        exp_mem[63] = 16'h8001;
        read_word(6'h3F, "R2 write addr63");

        // R3 / R8: erase with test bit set
        issue_cmd(16'h40C6);
        @(negedge clk);
        chk("R8 test bit readback", cmd_rdata & 16'h7FFF, 16'h40C6);
        wait_idle();
        exp_mem[6] = 16'hFFFF;
        read_word(6'd6, "R3 erase to ones");

        // R8: read with test bit still decodes normally
        issue_cmd(16'h4089);
        wait_idle();
        chk("R8 read with test bit", data_rdata, exp_mem[9]);
        chk("R8 cmd with test bit", cmd_rdata, 16'h4089);

        // R10: back-to-back reads (gap enforced by reference + checker)
        read_word(6'd7, "R10 back to back a");
        read_word(6'd8, "R10 back to back b");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule